// File: doc/BRIEF.md
# Audio Serial Clock Divider

This block derives the two clocks of a serial audio port, the bit clock and the frame (word-select) clock, from the master clock when the converter is the timing master of its link. A 3-bit mode code sets two things: whether the port is master or slave, and, in the master case, the ratio of master clock to sample rate. The bit clock always runs at 64 times the sample rate. The frame clock runs at the sample rate, so each frame holds 64 bit-clock periods.

When the port is slave, the block stops driving its clock pins. It lowers the pad enable and raises a slave flag, so the far end can supply the clocks. The two reserved codes are handled as slave mode and also raise an error flag. A power-down input holds both clocks low and clears the dividers. When power-down is released, the first frame therefore starts from a known phase.

Top module: `audio_mclk_div`

## Requirements
- R1: Mode codes 2, 3, 6 and 7 select master role with master-clock-to-sample-rate ratios of 256, 512, 384 and 768, which divide the master clock by 4, 8, 6 and 12 to make the bit clock.
- R2: In a running master mode the bit clock is high for exactly half of its divide ratio in master-clock cycles and low for the other half, so its period equals the divide ratio.
- R3: The frame clock has a period of 64 bit-clock periods and is high for 32 of them and low for 32. It changes only in the master-clock cycle in which the bit clock falls, so across one full frame exactly 64 bit-clock rising edges occur.
- R4: `clk_oe` is high in every master mode, whether or not power-down is asserted.
- R5: In a master mode, while `pwr_dn` is high, `bclk_o` and `lrck_o` are low. They drop in the same cycle in which `pwr_dn` rises.
- R6: Mode codes 0 and 4 select slave role: `clk_oe` is low, `is_slave` is high, `mode_err` is low, and both clock outputs are held low.
- R7: Mode codes 1 and 5 are reserved. They behave like slave role (`clk_oe` low, `is_slave` high, clocks low) and also raise `mode_err`.
- R8: After `pwr_dn` falls in a master mode with divide ratio N, the bit clock first rises N/2 master-clock edges later. The frame clock starts low and first rises 32·N edges later.
- R9: While `rst_n` is low, `bclk_o` and `lrck_o` are low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Power-down: holds the clocks low and clears the dividers |
| mode | input | 3 | Role and clock-ratio select code |
| bclk_o | output | 1 | Bit clock, 64 times the sample rate |
| lrck_o | output | 1 | Frame clock, at the sample rate |
| clk_oe | output | 1 | Pad drive enable for both clocks (low means high impedance) |
| is_slave | output | 1 | High in slave role and in the reserved codes |
| mode_err | output | 1 | High for a reserved mode code |

## Verification
The hardest case to reach from the ports is the frame edge under the divide-by-12 ratio. It comes only 384 master cycles after release, and there the phase of the frame clock against the falling bit clock must hold with a non-power-of-two divider. The stimulus table releases power-down in each of the eight codes and watches each master mode for a full frame and a half. It records the first edges of both clocks and counts the bit-clock rising edges inside one frame. Directed steps then force power-down, reset and a change of role while the frame clock is high, which is the state in which a late gating path would show.

// File: rtl/amd_pkg.sv
package amd_pkg;

   typedef enum logic [1:0] {
      ROLE_SLAVE  = 2'd0,
      ROLE_MASTER = 2'd1,
      ROLE_RSVD   = 2'd2
   } role_e;

   function automatic role_e role_of(input logic [2:0] code);
      role_e r;
      case (code)
         3'd2, 3'd3, 3'd6, 3'd7: r = ROLE_MASTER;
         3'd0, 3'd4:             r = ROLE_SLAVE;
         default:                r = ROLE_RSVD;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/amd_mode_decode.sv
module amd_mode_decode
   import amd_pkg::*;
#(
   parameter int HALF_W   = 3,
   parameter int HALF_256 = 2,
   parameter int HALF_384 = 3,
   parameter int HALF_512 = 4,
   parameter int HALF_768 = 6
)(
   input  logic [2:0]        mode,
   output logic              master,
   output logic              slave,
   output logic              rsvd,
   output logic [HALF_W-1:0] half
);

   role_e role;

   always_comb begin
      role   = role_of(mode);
      master = (role == ROLE_MASTER);
      slave  = (role != ROLE_MASTER);
      rsvd   = (role == ROLE_RSVD);
      case (mode)
         3'd2:    half = HALF_W'(HALF_256);
         3'd3:    half = HALF_W'(HALF_512);
         3'd6:    half = HALF_W'(HALF_384);
         3'd7:    half = HALF_W'(HALF_768);
         default: half = HALF_W'(HALF_256);
      endcase
   end

endmodule

// File: rtl/amd_bit_div.sv
module amd_bit_div #(
   parameter int HALF_W = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [HALF_W-1:0] half,
   output logic              bclk,
   output logic              fall_stb
);

   logic [HALF_W-1:0] cnt;
   logic              wrap;

   // ">=" keeps the counter bounded if the ratio shrinks while running
   assign wrap     = (cnt >= (half - 1'b1));
   assign fall_stb = run & wrap & bclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         bclk <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         bclk <= 1'b0;
      end else if (wrap) begin
         cnt  <= '0;
         bclk <= ~bclk;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/amd_frame_div.sv
module amd_frame_div #(
   parameter int FRAME_BITS = 64
)(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fall_stb,
   output logic lrck
);

   localparam int CW = $clog2(FRAME_BITS);

   logic [CW-1:0] bit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bit_cnt <= '0;
      else if (!run)     bit_cnt <= '0;
      else if (fall_stb) bit_cnt <= bit_cnt + 1'b1;
   end

   // top bit of the bit counter: low for the first half of the frame
   assign lrck = bit_cnt[CW-1];

endmodule

// File: rtl/audio_mclk_div.sv
module audio_mclk_div #(
   parameter int DIV_256    = 4,
   parameter int DIV_384    = 6,
   parameter int DIV_512    = 8,
   parameter int DIV_768    = 12,
   parameter int FRAME_BITS = 64,
   parameter bit OUT_REG    = 1'b0
)(
   input  logic       mclk,
   input  logic       rst_n,
   input  logic       pwr_dn,
   input  logic [2:0] mode,
   output logic       bclk_o,
   output logic       lrck_o,
   output logic       clk_oe,
   output logic       is_slave,
   output logic       mode_err
);

   localparam int MAX_A   = (DIV_256 > DIV_384) ? DIV_256 : DIV_384;
   localparam int MAX_B   = (DIV_512 > DIV_768) ? DIV_512 : DIV_768;
   localparam int MAX_DIV = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int HALF_W  = $clog2(MAX_DIV / 2 + 1);

   generate
      if ((DIV_256 % 2) != 0 || (DIV_384 % 2) != 0 ||
          (DIV_512 % 2) != 0 || (DIV_768 % 2) != 0) begin : g_bad_odd
         $error("audio_mclk_div: every divide ratio must be even for a 50 percent duty");
      end
      if (DIV_256 < 2 || DIV_384 < 2 || DIV_512 < 2 || DIV_768 < 2) begin : g_bad_small
         $error("audio_mclk_div: divide ratios must be at least 2");
      end
      if (FRAME_BITS < 4 || (FRAME_BITS & (FRAME_BITS - 1)) != 0) begin : g_bad_frame
         $error("audio_mclk_div: FRAME_BITS must be a power of two of at least 4");
      end
   endgenerate

   logic              master;
   logic              slave;
   logic              rsvd;
   logic [HALF_W-1:0] half;
   logic              run;
   logic              bclk_q;
   logic              fall_stb;
   logic              lrck_q;

   amd_mode_decode #(
      .HALF_W   (HALF_W),
      .HALF_256 (DIV_256 / 2),
      .HALF_384 (DIV_384 / 2),
      .HALF_512 (DIV_512 / 2),
      .HALF_768 (DIV_768 / 2)
   ) u_dec (
      .mode   (mode),
      .master (master),
      .slave  (slave),
      .rsvd   (rsvd),
      .half   (half)
   );

   assign run = master & ~pwr_dn;

   amd_bit_div #(
      .HALF_W (HALF_W)
   ) u_bdiv (
      .clk      (mclk),
      .rst_n    (rst_n),
      .run      (run),
      .half     (half),
      .bclk     (bclk_q),
      .fall_stb (fall_stb)
   );

   amd_frame_div #(
      .FRAME_BITS (FRAME_BITS)
   ) u_fdiv (
      .clk      (mclk),
      .rst_n    (rst_n),
      .run      (run),
      .fall_stb (fall_stb),
      .lrck     (lrck_q)
   );

   generate
      if (OUT_REG) begin : g_out_reg
         logic bclk_r;
         logic lrck_r;
         always_ff @(posedge mclk or negedge rst_n) begin
            if (!rst_n) begin
               bclk_r <= 1'b0;
               lrck_r <= 1'b0;
            end else begin
               bclk_r <= bclk_q & run;
               lrck_r <= lrck_q & run;
            end
         end
         assign bclk_o = bclk_r;
         assign lrck_o = lrck_r;
      end else begin : g_out_comb
         assign bclk_o = bclk_q & run;
         assign lrck_o = lrck_q & run;
      end
   endgenerate

   assign clk_oe   = master;
   assign is_slave = slave;
   assign mode_err = rsvd;

endmodule

// File: rtl/audio_mclk_div_chk.sv
module audio_mclk_div_chk #(
   parameter int DIV_256 = 4,
   parameter int DIV_384 = 6,
   parameter int DIV_512 = 8,
   parameter int DIV_768 = 12
)(
   input logic       mclk,
   input logic       rst_n,
   input logic       pwr_dn,
   input logic [2:0] mode,
   input logic       bclk_o,
   input logic       lrck_o,
   input logic       clk_oe,
   input logic       is_slave,
   input logic       mode_err
);

   logic [2:0] mode_q;
   logic       bclk_d;
   logic [7:0] hi_cnt;
   logic       clean;
   logic [7:0] exp_half;
   logic       is_mst;

   always_comb begin
      is_mst = (mode == 3'd2) || (mode == 3'd3) || (mode == 3'd6) || (mode == 3'd7);
      case (mode_q)
         3'd2:    exp_half = 8'(DIV_256 / 2);
         3'd3:    exp_half = 8'(DIV_512 / 2);
         3'd6:    exp_half = 8'(DIV_384 / 2);
         3'd7:    exp_half = 8'(DIV_768 / 2);
         default: exp_half = 8'd0;
      endcase
   end

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 3'd0;
         bclk_d <= 1'b0;
         hi_cnt <= 8'd0;
         clean  <= 1'b0;
      end else begin
         mode_q <= mode;
         bclk_d <= bclk_o;
         hi_cnt <= bclk_o ? hi_cnt + 8'd1 : 8'd0;
         if (pwr_dn || !is_mst || (mode != mode_q)) clean <= 1'b0;
         else if (bclk_o && !bclk_d)               clean <= 1'b1;
      end
   end

   assert_high_len_R2: assert property (@(posedge mclk) disable iff (!rst_n)
      (clean && bclk_d && !bclk_o && !pwr_dn && !$past(pwr_dn) && is_mst)
         |-> (hi_cnt == exp_half));

   assert_frame_on_fall_R3: assert property (@(posedge mclk) disable iff (!rst_n)
      ((lrck_o != $past(lrck_o)) && !pwr_dn && !$past(pwr_dn) && is_mst && $past(is_mst))
         |-> $fell(bclk_o));

   assert_master_drives_R4: assert property (@(posedge mclk) disable iff (!rst_n)
      is_mst |-> (clk_oe && !is_slave));

   assert_pd_quiet_R5: assert property (@(posedge mclk) disable iff (!rst_n)
      (pwr_dn && $past(pwr_dn)) |-> (!bclk_o && !lrck_o));

   assert_slave_hiz_R6: assert property (@(posedge mclk) disable iff (!rst_n)
      is_slave |-> (!clk_oe && !bclk_o && !lrck_o));

   assert_rsvd_flag_R7: assert property (@(posedge mclk) disable iff (!rst_n)
      mode_err |-> is_slave);

endmodule

bind audio_mclk_div audio_mclk_div_chk #(
   .DIV_256 (DIV_256),
   .DIV_384 (DIV_384),
   .DIV_512 (DIV_512),
   .DIV_768 (DIV_768)
) u_chk (.*);

// File: tb/audio_mclk_div_tb_top.sv
module audio_mclk_div_tb_top;

   logic       mclk = 1'b0;
   logic       rst_n;
   logic       pwr_dn;
   logic [2:0] mode;
   logic       bclk_o;
   logic       lrck_o;
   logic       clk_oe;
   logic       is_slave;
   logic       mode_err;

   int n_chk = 0;
   int n_bad = 0;

   always #10 mclk = ~mclk;

   audio_mclk_div dut_i (
      .mclk     (mclk),
      .rst_n    (rst_n),
      .pwr_dn   (pwr_dn),
      .mode     (mode),
      .bclk_o   (bclk_o),
      .lrck_o   (lrck_o),
      .clk_oe   (clk_oe),
      .is_slave (is_slave),
      .mode_err (mode_err)
   );

   // fields: mode[9:7] master[6] slave[5] err[4] half_period[3:0]
   localparam logic [9:0] VEC [0:7] = '{
      {3'd0, 1'b0, 1'b1, 1'b0, 4'd0},
      {3'd1, 1'b0, 1'b1, 1'b1, 4'd0},
      {3'd2, 1'b1, 1'b0, 1'b0, 4'd2},
      {3'd3, 1'b1, 1'b0, 1'b0, 4'd4},
      {3'd4, 1'b0, 1'b1, 1'b0, 4'd0},
      {3'd5, 1'b0, 1'b1, 1'b1, 4'd0},
      {3'd6, 1'b1, 1'b0, 1'b0, 4'd3},
      {3'd7, 1'b1, 1'b0, 1'b0, 4'd6}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic measure(input int h);
      logic pb = 1'b0, pl = 1'b0, b, l;
      int br1 = -1, br2 = -1, bf1 = -1, lr1 = -1, lr2 = -1, lf1 = -1;
      int rises = 0, misalign = 0;
      for (int i = 1; i <= 192 * h + 4; i++) begin
         @(negedge mclk);
         b = bclk_o;
         l = lrck_o;
         if (b && !pb) begin
            if (br1 < 0) br1 = i; else if (br2 < 0) br2 = i;
            if (lr1 >= 0 && lr2 < 0) rises++;
         end
         if (!b && pb && bf1 < 0) bf1 = i;
         if (l != pl) begin
            if (!(pb && !b)) misalign++;
            if (l) begin
               if (lr1 < 0) lr1 = i; else if (lr2 < 0) lr2 = i;
            end else if (lf1 < 0) lf1 = i;
         end
         pb = b;
         pl = l;
      end
      chk("R8", "first bit clock rise", br1, h);
      chk("R2", "bit clock high cycles", bf1 - br1, h);
      chk("R2", "bit clock period", br2 - br1, 2 * h);
      chk("R8", "first frame rise", lr1, 64 * h);
      chk("R3", "frame high cycles", lf1 - lr1, 64 * h);
      chk("R3", "frame period", lr2 - lr1, 128 * h);
      chk("R3", "bit rises per frame", rises, 64);
      chk("R3", "frame edges off bit fall", misalign, 0);
   endtask

   initial begin
      repeat (200000) @(posedge mclk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n  = 1'b0;
      pwr_dn = 1'b0;
      mode   = 3'd2;
      repeat (3) @(negedge mclk);
      // R9: reset holds clocks low
      chk("R9", "bclk in reset", int'(bclk_o), 0);
      chk("R9", "lrck in reset", int'(lrck_o), 0);
      rst_n = 1'b1;

      // table walk: every code, released from power-down
      for (int v = 0; v < 8; v++) begin
         @(negedge mclk);
         mode   = VEC[v][9:7];
         pwr_dn = 1'b1;
         repeat (2) @(negedge mclk);
         chk("R1", "clk_oe per code", int'(clk_oe), int'(VEC[v][6]));
         chk("R6", "is_slave per code", int'(is_slave), int'(VEC[v][5]));
         chk("R7", "mode_err per code", int'(mode_err), int'(VEC[v][4]));
         chk("R5", "clocks low in power-down", int'(bclk_o | lrck_o), 0);
         if (VEC[v][6]) chk("R4", "oe held in power-down", int'(clk_oe), 1);
         pwr_dn = 1'b0;
         if (VEC[v][6]) begin
            measure(int'(VEC[v][3:0]));
         end else begin
            int busy = 0;
            for (int i = 0; i < 200; i++) begin
               @(negedge mclk);
               if (bclk_o || lrck_o || clk_oe) busy++;
            end
            chk(VEC[v][4] ? "R7" : "R6", "slave outputs quiet", busy, 0);
         end
      end

      // R5: power-down while frame clock high drops both at once
      @(negedge mclk);
      mode   = 3'd7;
      pwr_dn = 1'b1;
      @(negedge mclk);
      pwr_dn = 1'b0;
      while (!(lrck_o && bclk_o)) @(negedge mclk);
      pwr_dn = 1'b1;
      #1;
      chk("R5", "bclk drops with pwr_dn", int'(bclk_o), 0);
      chk("R5", "lrck drops with pwr_dn", int'(lrck_o), 0);
      chk("R4", "oe stays in power-down", int'(clk_oe), 1);
      repeat (20) @(negedge mclk);
      chk("R5", "clocks stay low", int'(bclk_o | lrck_o), 0);

      // R8: release again, dividers restart aligned (ratio 384)
      mode   = 3'd6;
      pwr_dn = 1'b0;
      measure(3);

      // R6: switch to slave mid-frame
      while (!lrck_o) @(negedge mclk);
      mode = 3'd4;
      #1;
      chk("R6", "oe off on slave switch", int'(clk_oe), 0);
      chk("R6", "clocks low on slave switch", int'(bclk_o | lrck_o), 0);
      chk("R6", "slave flag", int'(is_slave), 1);

      // R7: reserved code raises error
      @(negedge mclk);
      mode = 3'd1;
      #1;
      chk("R7", "reserved error flag", int'(mode_err), 1);
      chk("R7", "reserved oe off", int'(clk_oe), 0);

      // R9: asynchronous reset mid-run
      @(negedge mclk);
      mode = 3'd3;
      while (!lrck_o) @(negedge mclk);
      rst_n = 1'b0;
      #1;
      chk("R9", "async reset bclk", int'(bclk_o), 0);
      chk("R9", "async reset lrck", int'(lrck_o), 0);
      @(negedge mclk);
      rst_n = 1'b1;
      measure(4);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule